// File: doc/BRIEF.md
# Audio Frame DMA Address Sequencer

This block produces the memory word addresses for a playback stream and a record stream. Each stream walks a buffer from a start address to an end address. Software programs the block through a byte-wide register port. That port holds a control byte, an event-routing byte, and the start, current and end address registers. Playback and record each have their own start and end registers. Both sets sit behind the same register offsets, and a bank bit in the control byte picks which set the CPU reaches.

One request line serves both streams, and playback wins whenever both are enabled. Every acknowledged transfer moves the active stream's counter forward by one 16-bit word. When the transfer at the end address is acknowledged, the stream pulses its frame-done output. It then either reloads its start address, if repeat is set, or switches itself off. Two interrupt lines each use their own 2-bit code to select which frame-done events they pass on.

Top module: `audio_dma_seq`

## Requirements
- R1: After reset the control byte, the routing byte and every address register read as zero. `dma_req`, both done outputs and both interrupt outputs are low.
- R2: Register offsets:
  - 0 is the control byte.
  - 1 is the routing byte.
  - 2..4 are the start address, 5..7 the current address and 8..10 the end address, each listed high byte first.
  Control bit 7 selects the bank: 0 for playback, 1 for record. The two banks are separate storage. Only control bits 0, 1, 4, 5 and 7 and routing bits 0..3 are kept; all other bits read as zero.
- R3: Bit 0 of every start, end and current address is always zero. A write of an odd low byte reads back with bit 0 cleared.
- R4: Writing control bit 0 (playback) or bit 4 (record) from 0 to 1 loads that stream's counter from its start register. An enabled stream is served by `dma_req`. Each cycle with `dma_ack` high moves the served stream's counter up by 2, and `dma_addr` shows that counter.
- R5: When a transfer is acknowledged while the counter equals the end address, the stream's done output is high for exactly the next cycle. Without repeat, the stream's enable bit then reads as 0 and its counter keeps the end address.
- R6: Playback repeat is control bit 1 and record repeat is bit 5. With repeat set, the counter reloads the start address after the end transfer, the stream stays enabled, and done pulses once per frame.
- R7: With both streams enabled, playback is served (`dma_sel_rec` = 0) and the record counter does not move. Record is served (`dma_sel_rec` = 1) once playback is disabled.
- R8: Routing bits 1:0 control `irq_timer`:
  - 00: never.
  - 01: playback frame end.
  - 10: record frame end.
  - 11: either.
  The pulse is high in the same cycle as the done output.
- R9: Routing bits 3:2 control `irq_gpio` using the same four codes and the same timing as R8.
- R10: The current-address registers read back the selected bank's counter. CPU writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | CPU_AW (4) | Register offset |
| cpu_we | input | 1 | Byte write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| dma_req | output | 1 | A stream is enabled and wants a transfer |
| dma_sel_rec | output | 1 | 1 when the record stream is being served |
| dma_addr | output | ADDR_W (24) | Word address of the current transfer |
| dma_ack | input | 1 | Transfer accepted this cycle |
| play_done | output | 1 | One-cycle playback frame-end pulse |
| rec_done | output | 1 | One-cycle record frame-end pulse |
| irq_timer | output | 1 | Routed frame-end pulse, timer line |
| irq_gpio | output | 1 | Routed frame-end pulse, general-purpose line |

## Verification
The bench sweeps frame lengths from one word upward for each stream.

- **Frame end off by one.** A design that compares the end address at the wrong point would give a one-word frame two transfers, or none. The bench follows every frame cycle by cycle to catch this.
- **Routing codes.** All sixteen routing combinations are run against both stream types. A swapped code bit would send record events to the playback-only setting.
- **Priority and bank separation.** The bench enables both streams together and checks that playback is served first. It also writes the record bank and reads the playback bank back, to catch a design that aliases the two banks.
- **Forced-zero bit 0.** Odd low bytes are written to start and end registers to check that bit 0 reads back as zero.
- **Current-address writes.** Writes are aimed at the current-address offsets to check that they are ignored.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

    // control byte bit positions
    localparam int CTL_PLAY_EN  = 0;
    localparam int CTL_PLAY_RPT = 1;
    localparam int CTL_REC_EN   = 4;
    localparam int CTL_REC_RPT  = 5;
    localparam int CTL_BANK     = 7;
    localparam logic [7:0] CTL_KEEP   = 8'hB3;
    localparam logic [7:0] ROUTE_KEEP = 8'h0F;

    // offset between the two streams' bits in the control byte
    localparam int CTL_STRIDE = 4;

    typedef enum logic [1:0] {
        EVT_NONE = 2'b00,
        EVT_PLAY = 2'b01,
        EVT_REC  = 2'b10,
        EVT_ANY  = 2'b11
    } evt_route_e;

    function automatic logic route_hit(input logic [1:0] code, input logic p_evt, input logic r_evt);
        return (code[0] & p_evt) | (code[1] & r_evt);
    endfunction

endpackage

// File: rtl/audio_dma_chan.sv
module audio_dma_chan #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          en_i,
    input  logic          rpt_i,
    input  logic          ack_i,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] end_i,
    output logic [AW-1:0] cnt_o,
    output logic          last_o,
    output logic          clr_o,
    output logic          done_o
);

    typedef struct packed {
        logic [AW-1:0] cnt;
        logic          done;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     at_end;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        at_end    = (st_q.cnt == end_i);
        last_o    = en_i & ack_i & at_end;
        clr_o     = last_o & ~rpt_i;
        if (load_i) begin
            st_d.cnt = start_i;
        end else if (en_i && ack_i) begin
            if (at_end) begin
                st_d.done = 1'b1;
                if (rpt_i) begin
                    st_d.cnt = start_i;
                end
            end else begin
                st_d.cnt = st_q.cnt + AW'(2);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign done_o = st_q.done;

    // R4
    step_by_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ack_i && !load_i && st_q.cnt != end_i) |=> (st_q.cnt == $past(st_q.cnt) + AW'(2)));

    // R6
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ack_i && !load_i && st_q.cnt == end_i && rpt_i) |=> (st_q.cnt == $past(start_i)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ack_i && !load_i && st_q.cnt == end_i) |=> done_o);

    // R3
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt[0] == 1'b0));

endmodule

// File: rtl/audio_evt_router.sv
module audio_evt_router (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       play_evt_i,
    input  logic       rec_evt_i,
    input  logic [1:0] tmr_code_i,
    input  logic [1:0] gp_code_i,
    output logic       irq_tmr_o,
    output logic       irq_gp_o
);
    import audio_dma_pkg::*;

    typedef struct packed {
        logic tmr;
        logic gp;
    } rt_st_t;

    rt_st_t st_d, st_q;

    always_comb begin
        st_d.tmr = route_hit(tmr_code_i, play_evt_i, rec_evt_i);
        st_d.gp  = route_hit(gp_code_i, play_evt_i, rec_evt_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_tmr_o = st_q.tmr;
    assign irq_gp_o  = st_q.gp;

    // R8
    tmr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tmr_o |-> $past(play_evt_i || rec_evt_i));

    // R9
    gp_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_gp_o |-> ($past(gp_code_i) != EVT_NONE));

endmodule

// File: rtl/audio_dma_seq.sv
module audio_dma_seq #(
    parameter int ADDR_W = 24,
    parameter int CPU_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              dma_req,
    output logic              dma_sel_rec,
    output logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_ack,
    output logic              play_done,
    output logic              rec_done,
    output logic              irq_timer,
    output logic              irq_gpio
);
    import audio_dma_pkg::*;

    localparam int NB        = ADDR_W / 8;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_ROUTE = 1;
    localparam int OFS_START = 2;
    localparam int OFS_CUR   = OFS_START + NB;
    localparam int OFS_END   = OFS_CUR + NB;
    localparam int NCH       = 2;

    typedef struct packed {
        logic [7:0]                  ctrl;
        logic [7:0]                  route;
        logic [NCH-1:0][ADDR_W-1:0]  start;
        logic [NCH-1:0][ADDR_W-1:0]  stop;
    } reg_st_t;

    reg_st_t st_d, st_q;

    logic [NCH-1:0][ADDR_W-1:0] chan_cnt;
    logic [NCH-1:0]             chan_last;
    logic [NCH-1:0]             chan_clr;
    logic [NCH-1:0]             chan_done;
    logic [NCH-1:0]             chan_ack;
    logic [NCH-1:0]             chan_load;
    logic [NCH-1:0]             chan_en;
    logic                       ctrl_wr;
    logic                       bank;

    assign bank    = st_q.ctrl[CTL_BANK];
    assign ctrl_wr = cpu_we && (cpu_addr == CPU_AW'(OFS_CTRL));

    // register file next state
    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.ctrl = cpu_wdata & CTL_KEEP;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (chan_clr[c]) begin
                    st_d.ctrl[c*CTL_STRIDE] = 1'b0;
                end
            end
        end
        if (cpu_we && cpu_addr == CPU_AW'(OFS_ROUTE)) begin
            st_d.route = cpu_wdata & ROUTE_KEEP;
        end
        for (int k = 0; k < NB; k++) begin
            if (cpu_we && cpu_addr == CPU_AW'(OFS_START + k)) begin
                st_d.start[bank][ADDR_W-1-8*k -: 8] = cpu_wdata;
            end
            if (cpu_we && cpu_addr == CPU_AW'(OFS_END + k)) begin
                st_d.stop[bank][ADDR_W-1-8*k -: 8] = cpu_wdata;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            st_d.start[c][0] = 1'b0;
            st_d.stop[c][0]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        cpu_rdata = 8'h00;
        if (cpu_addr == CPU_AW'(OFS_CTRL)) begin
            cpu_rdata = st_q.ctrl;
        end
        if (cpu_addr == CPU_AW'(OFS_ROUTE)) begin
            cpu_rdata = st_q.route;
        end
        for (int k = 0; k < NB; k++) begin
            if (cpu_addr == CPU_AW'(OFS_START + k)) begin
                cpu_rdata = st_q.start[bank][ADDR_W-1-8*k -: 8];
            end
            if (cpu_addr == CPU_AW'(OFS_CUR + k)) begin
                cpu_rdata = chan_cnt[bank][ADDR_W-1-8*k -: 8];
            end
            if (cpu_addr == CPU_AW'(OFS_END + k)) begin
                cpu_rdata = st_q.stop[bank][ADDR_W-1-8*k -: 8];
            end
        end
    end

    // arbitration: stream 0 (playback) first
    always_comb begin
        chan_en[0]  = st_q.ctrl[CTL_PLAY_EN];
        chan_en[1]  = st_q.ctrl[CTL_REC_EN];
        dma_req     = |chan_en;
        dma_sel_rec = ~chan_en[0] & chan_en[1];
        chan_ack[0] = dma_ack & chan_en[0];
        chan_ack[1] = dma_ack & dma_sel_rec;
        dma_addr    = dma_sel_rec ? chan_cnt[1] : chan_cnt[0];
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign chan_load[c] = ctrl_wr && cpu_wdata[c*CTL_STRIDE] && !st_q.ctrl[c*CTL_STRIDE];

        audio_dma_chan #(
            .AW(ADDR_W)
        ) chan_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (chan_load[c]),
            .en_i    (chan_en[c]),
            .rpt_i   (st_q.ctrl[c*CTL_STRIDE+1]),
            .ack_i   (chan_ack[c]),
            .start_i (st_q.start[c]),
            .end_i   (st_q.stop[c]),
            .cnt_o   (chan_cnt[c]),
            .last_o  (chan_last[c]),
            .clr_o   (chan_clr[c]),
            .done_o  (chan_done[c])
        );
    end

    audio_evt_router router_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_evt_i (chan_last[0]),
        .rec_evt_i  (chan_last[1]),
        .tmr_code_i (st_q.route[1:0]),
        .gp_code_i  (st_q.route[3:2]),
        .irq_tmr_o  (irq_timer),
        .irq_gp_o   (irq_gpio)
    );

    assign play_done = chan_done[0];
    assign rec_done  = chan_done[1];

    // R5
    play_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_clr[0] && !ctrl_wr) |=> !st_q.ctrl[CTL_PLAY_EN]);

    // R7
    rec_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl[CTL_PLAY_EN] && st_q.ctrl[CTL_REC_EN] && !chan_load[1]) |=> $stable(chan_cnt[1]));

    // R8
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timer |-> (play_done || rec_done));

endmodule

// File: tb/audio_dma_seq_tb.sv
module audio_dma_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        dma_req, dma_sel_rec, dma_ack = 1'b0;
    logic [23:0] dma_addr;
    logic        play_done, rec_done, irq_timer, irq_gpio;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    audio_dma_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .dma_req(dma_req),
        .dma_sel_rec(dma_sel_rec), .dma_addr(dma_addr), .dma_ack(dma_ack),
        .play_done(play_done), .rec_done(rec_done), .irq_timer(irq_timer),
        .irq_gpio(irq_gpio)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(posedge clk); @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        cpu_addr = a; #1; d = cpu_rdata;
    endtask

    task automatic wr24(input logic [3:0] base, input logic [23:0] v);
        wr(base, v[23:16]); wr(base + 4'd1, v[15:8]); wr(base + 4'd2, v[7:0]);
    endtask

    task automatic rd24(input logic [3:0] base, output logic [23:0] v);
        logic [7:0] b;
        rd(base, b); v[23:16] = b;
        rd(base + 4'd1, b); v[15:8] = b;
        rd(base + 4'd2, b); v[7:0] = b;
    endtask

    // one full frame on one stream, no repeat; checks addresses, end and routing
    task automatic run_frame(input bit rec, input logic [23:0] s, input int len,
                             input logic exp_t, input logic exp_g, input string rq);
        logic [23:0] e, v;
        logic [7:0]  b;
        e = s + 24'(2 * (len - 1));
        wr(4'd0, rec ? 8'h80 : 8'h00);
        wr24(4'd2, s);
        wr24(4'd8, e);
        dma_ack = 1'b1;
        wr(4'd0, rec ? 8'h90 : 8'h01);
        for (int i = 0; i < len; i++) begin
            chk("R4", "req", 32'(dma_req), 32'd1);
            chk("R4", "addr", 32'(dma_addr), 32'(s + 24'(2 * i)));
            chk("R7", "sel", 32'(dma_sel_rec), 32'(rec));
            chk("R5", "early done", 32'(rec ? rec_done : play_done), 32'd0);
            @(posedge clk); @(negedge clk);
        end
        chk("R5", "done", 32'(rec ? rec_done : play_done), 32'd1);
        chk("R5", "req off", 32'(dma_req), 32'd0);
        chk(rq, "irq_timer", 32'(irq_timer), 32'(exp_t));
        chk(rq, "irq_gpio", 32'(irq_gpio), 32'(exp_g));
        rd(4'd0, b);
        chk("R5", "enable cleared", 32'(b), rec ? 32'h80 : 32'h00);
        rd24(4'd5, v);
        chk("R10", "current holds end", 32'(v), 32'(e));
        @(posedge clk); @(negedge clk);
        chk("R5", "done one cycle", 32'(rec ? rec_done : play_done), 32'd0);
        chk(rq, "irq one cycle", 32'({irq_timer, irq_gpio}), 32'd0);
        dma_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, b);  chk("R1", "ctrl", 32'(b), 32'h0);
        rd(4'd1, b);  chk("R1", "route", 32'(b), 32'h0);
        rd24(4'd2, v); chk("R1", "start", 32'(v), 32'h0);
        rd24(4'd5, v); chk("R1", "current", 32'(v), 32'h0);
        rd24(4'd8, v); chk("R1", "end", 32'(v), 32'h0);
        chk("R1", "outputs", 32'({dma_req, play_done, rec_done, irq_timer, irq_gpio}), 32'h0);

        // R2 unused control bits read zero and enable nothing
        wr(4'd0, 8'h4C);
        rd(4'd0, b); chk("R2", "ctrl mask", 32'(b), 32'h0);
        chk("R2", "no req", 32'(dma_req), 32'd0);
        wr(4'd1, 8'hF0);
        rd(4'd1, b); chk("R2", "route mask", 32'(b), 32'h0);

        // R3 bit 0 forced low
        wr24(4'd2, 24'h123457);
        rd24(4'd2, v); chk("R3", "start lsb", 32'(v), 32'h123456);
        wr24(4'd8, 24'hABCDEF);
        rd24(4'd8, v); chk("R3", "end lsb", 32'(v), 32'hABCDEE);

        // R2 bank separation
        wr(4'd0, 8'h80);
        wr24(4'd2, 24'h654320);
        rd24(4'd2, v); chk("R2", "rec start", 32'(v), 32'h654320);
        wr(4'd0, 8'h00);
        rd24(4'd2, v); chk("R2", "play start kept", 32'(v), 32'h123456);

        // R10 writes to current ignored
        wr(4'd5, 8'hFF); wr(4'd7, 8'h11);
        rd24(4'd5, v); chk("R10", "current write ignored", 32'(v), 32'h0);

        // R4/R5 frame lengths on both streams
        for (int n = 1; n <= 4; n++) begin
            run_frame(1'b0, 24'h001000 + 24'(n * 64), n, 1'b0, 1'b0, "R8");
            run_frame(1'b1, 24'h7FFFF0 + 24'(n * 32), n, 1'b0, 1'b0, "R8");
        end

        // R6 repeat on playback
        wr(4'd0, 8'h00);
        wr24(4'd2, 24'h000100);
        wr24(4'd8, 24'h000104);
        dma_ack = 1'b1;
        wr(4'd0, 8'h03);
        for (int i = 0; i < 7; i++) begin
            chk("R6", "repeat addr", 32'(dma_addr), 32'(24'h000100 + 24'(2 * (i % 3))));
            chk("R6", "repeat done", 32'(play_done), 32'((i > 0) && (i % 3 == 0)));
            @(posedge clk); @(negedge clk);
        end
        rd(4'd0, b); chk("R6", "still enabled", 32'(b), 32'h03);
        wr(4'd0, 8'h00);
        chk("R6", "stopped", 32'(dma_req), 32'd0);
        dma_ack = 1'b0;

        // R7 playback priority
        wr24(4'd2, 24'h001000); wr24(4'd8, 24'h001002);
        wr(4'd0, 8'h80);
        wr24(4'd2, 24'h002000); wr24(4'd8, 24'h002002);
        dma_ack = 1'b1;
        wr(4'd0, 8'h11);
        for (int i = 0; i < 4; i++) begin
            chk("R7", "sel", 32'(dma_sel_rec), 32'(i >= 2));
            chk("R7", "addr", 32'(dma_addr), (i < 2) ? 32'(24'h001000 + 24'(2 * i)) : 32'(24'h002000 + 24'(2 * (i - 2))));
            chk("R7", "play done", 32'(play_done), 32'(i == 2));
            @(posedge clk); @(negedge clk);
        end
        chk("R7", "rec done", 32'(rec_done), 32'd1);
        dma_ack = 1'b0;
        @(negedge clk);

        // R8 / R9 routing sweep
        for (int t = 0; t < 4; t++) begin
            for (int g = 0; g < 4; g++) begin
                wr(4'd1, 8'((g << 2) | t));
                run_frame(1'b0, 24'h000400, 1, 1'(t & 1), 1'(g & 1), (t == g) ? "R8" : "R9");
                run_frame(1'b1, 24'h000800, 1, 1'(t >> 1), 1'(g >> 1), (t == g) ? "R9" : "R8");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule